// File: doc/BRIEF.md
# Shared-Timer Input Debounce Filter

This block cleans up a bank of slow, noisy input pins. Every pin first passes through a two-flop synchronizer. It then goes to a stability filter of its own. The filter moves the pin's clean output to a new level only after the synchronized input has held that level for a programmed number of clock cycles. Any bounce that ends sooner is discarded.

The bank has only three period registers, and all pins share them. Each pin picks one of the three with a 2-bit selector, or picks none, in which case its synchronized input goes straight to the output. The two selector bits of a pin sit in the same bit position of two separate select registers. Software therefore changes a pin's choice by updating that bit in both registers. A small synchronous write port with a combinational read port holds all five registers. Converting time to cycles and deciding which pins share a timer are left to software.

Top module: `shdb_filter`

## Requirements
- R1: After reset every filtered output is 0, and every register reads 0: both select registers and all three period registers.
- R2: A pin whose selector is 0 passes its raw input to the filtered output with a latency of exactly three clock edges. There are two synchronizer edges plus one output edge.
- R3: A pin whose selector is 1, 2 or 3, using a period P of 1 or more, changes its filtered output P+2 edges after a raw input change that then holds. At edge P+1 the output still shows the old level.
- R4: If the raw input returns to the filtered level before the synchronized input has differed for P cycles, the filtered output does not change.
- R5: A pin's selector is {select-high bit n, select-low bit n}. Pin n uses bit n of the register at address 0 for the high bit and bit n of the register at address 1 for the low bit. Values 1, 2 and 3 choose the period registers at addresses 2, 3 and 4. Each pin follows its own selector.
- R6: A selected period register that holds 0 behaves as pass-through, with the same latency as R2.
- R7: The period registers read back the value written to them, zero-extended. Addresses 5 to 7 read 0, and writes to them change no register.
- R8: Select bits of pins that the IN_CAP parameter marks as not input-capable cannot be set. They read 0, and such pins always pass through.
- R9: A new value written to a period register applies to every pin that selects that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; periods count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 3 | Register address for both write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| pin_raw | input | NPINS | Asynchronous raw pin levels |
| pin_out | output | NPINS | Debounced pin levels |

## Verification
A wrong selector or period shows up as a filtered edge on the wrong cycle, so every edge check samples both the last cycle that must still show the old level and the first cycle that must show the new one. A counter that fails to restart or to compare shows up within a single period: a short glitch gets through, or a clean edge arrives early or late. A masking or decoding fault in the register file shows up at once on the read port, or three cycles later on a pass-through pin.

// File: rtl/shdb_pkg.sv
package shdb_pkg;
   localparam int ADDR_W = 3;
   localparam int NTMR   = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_SEL_HI = 3'd0,
      RA_SEL_LO = 3'd1,
      RA_PER1   = 3'd2,
      RA_PER2   = 3'd3,
      RA_PER3   = 3'd4
   } shdb_reg_e;
endpackage

// File: rtl/shdb_sync.sv
module shdb_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/shdb_regs.sv
module shdb_regs
   import shdb_pkg::*;
#(
   parameter int               NPINS  = 32,
   parameter int               DATA_W = 32,
   parameter int               CNT_W  = 16,
   parameter logic [NPINS-1:0] IN_CAP = '1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [NPINS-1:0]           sel_hi,
   output logic [NPINS-1:0]           sel_lo,
   output logic [NTMR-1:0][CNT_W-1:0] period
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_hi <= '0;
         sel_lo <= '0;
         period <= '0;
      end else if (wr) begin
         case (addr)
            RA_SEL_HI: sel_hi    <= wdata[NPINS-1:0] & IN_CAP;
            RA_SEL_LO: sel_lo    <= wdata[NPINS-1:0] & IN_CAP;
            RA_PER1:   period[0] <= wdata[CNT_W-1:0];
            RA_PER2:   period[1] <= wdata[CNT_W-1:0];
            RA_PER3:   period[2] <= wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_SEL_HI: rdata[NPINS-1:0] = sel_hi;
         RA_SEL_LO: rdata[NPINS-1:0] = sel_lo;
         RA_PER1:   rdata[CNT_W-1:0] = period[0];
         RA_PER2:   rdata[CNT_W-1:0] = period[1];
         RA_PER3:   rdata[CNT_W-1:0] = period[2];
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/shdb_lane.sv
module shdb_lane #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [CNT_W-1:0] period,
   output logic             dout
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dout  <= 1'b0;
      end else if (period == '0) begin
         cnt_q <= '0;
         dout  <= din;
      end else if (din == dout) begin
         cnt_q <= '0;
      end else if (cnt_q >= period - CNT_W'(1)) begin
         cnt_q <= '0;
         dout  <= din;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/shdb_filter.sv
module shdb_filter
   import shdb_pkg::*;
#(
   parameter int               NPINS  = 32,
   parameter int               DATA_W = 32,
   parameter int               CNT_W  = 16,
   parameter logic [NPINS-1:0] IN_CAP = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NPINS-1:0]  pin_raw,
   output logic [NPINS-1:0]  pin_out
);
   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("shdb_filter: NPINS must lie in 1..DATA_W");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cntw
      $error("shdb_filter: CNT_W must lie in 1..DATA_W");
   end

   logic [NPINS-1:0]           sel_hi_w;
   logic [NPINS-1:0]           sel_lo_w;
   logic [NTMR-1:0][CNT_W-1:0] period_w;
   logic [NPINS-1:0]           sync_w;

   shdb_regs #(
      .NPINS(NPINS), .DATA_W(DATA_W), .CNT_W(CNT_W), .IN_CAP(IN_CAP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .sel_hi(sel_hi_w), .sel_lo(sel_lo_w), .period(period_w)
   );

   shdb_sync #(.W(NPINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_w)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [1:0]       sel;
      logic [CNT_W-1:0] per;
      assign sel = {sel_hi_w[i], sel_lo_w[i]};
      always_comb begin
         case (sel)
            2'd1:    per = period_w[0];
            2'd2:    per = period_w[1];
            2'd3:    per = period_w[2];
            default: per = '0;
         endcase
      end
      shdb_lane #(.CNT_W(CNT_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .din(sync_w[i]), .period(per),
         .dout(pin_out[i])
      );
   end
endmodule

// File: rtl/shdb_checker.sv
module shdb_checker #(
   parameter int               NPINS  = 32,
   parameter int               DATA_W = 32,
   parameter logic [NPINS-1:0] IN_CAP = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NPINS-1:0]  pin_raw,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  sel_hi,
   input logic [NPINS-1:0]  sel_lo
);
   localparam logic [DATA_W-1:0] CAPX = DATA_W'(IN_CAP);

   logic [2:0]       cyc_q;
   logic [NPINS-1:0] byp;
   assign byp = ~(sel_hi | sel_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cyc_q <= '0;
      else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
   end

   a_r1_reset_out: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 3'd0) |-> (pin_out == '0));

   a_r2_bypass_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 3'd4) |-> (((pin_out ^ $past(pin_raw, 3)) & $past(byp)) == '0));

   a_r3_edge_from_input: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 3'd4) |->
      ((((pin_out ^ $past(pin_out)) & (pin_out ^ $past(pin_raw, 3)))) == '0));

   a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr > 3'd4) |-> (reg_rdata == '0));

   a_r8_noncap_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr <= 3'd1) |-> ((reg_rdata & ~CAPX) == '0));
endmodule

bind shdb_filter shdb_checker #(
   .NPINS(NPINS), .DATA_W(DATA_W), .IN_CAP(IN_CAP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .pin_raw(pin_raw), .pin_out(pin_out), .sel_hi(sel_hi_w), .sel_lo(sel_lo_w)
);

// File: tb/shdb_filter_bench.sv
module shdb_filter_bench;
   localparam int NP = 32;
   localparam int DW = 32;
   localparam logic [NP-1:0] CAP = 32'h7FFF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NP-1:0] pin_raw = '0;
   logic [NP-1:0] pin_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   shdb_filter #(.NPINS(NP), .DATA_W(DW), .CNT_W(16), .IN_CAP(CAP)) u_shdb_filter (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_raw(pin_raw), .pin_out(pin_out)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 outputs", pin_out, 32'h0);
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         chk("R1 register", d, 32'h0);
      end
   endtask

   task automatic t_regs;
      logic [31:0] d;
      wr(3'd2, 32'h0000_0005);
      wr(3'd3, 32'h0000_0009);
      wr(3'd4, 32'h0000_0003);
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd2, d); chk("R7 period1", d, 32'd5);
      rd(3'd3, d); chk("R7 period2", d, 32'd9);
      rd(3'd4, d); chk("R7 period3", d, 32'd3);
      rd(3'd6, d); chk("R7 unmapped", d, 32'h0);
      rd(3'd0, d); chk("R7 sel_hi untouched", d, 32'h0);
      // pin1 sel1, pin2 sel2, pin3 sel3, pins 4/5 sel1, pin31 request masked
      wr(3'd0, 32'h0000_000C);
      wr(3'd1, 32'h8000_003A);
      rd(3'd1, d); chk("R8 select masked", d, 32'h0000_003A);
   endtask

   task automatic t_bypass;
      logic [2:0] pat [10];
      for (int i = 0; i < 10; i++) begin
         pat[i] = 3'((i * 5 + 1) % 8);
         pin_raw[0] = pat[i][0]; pin_raw[6] = pat[i][1]; pin_raw[7] = pat[i][2];
         tick(1);
         if (i >= 2)
            chk("R2 bypass", {29'd0, pin_out[7], pin_out[6], pin_out[0]},
                {29'd0, pat[i-2]});
      end
      pin_raw = '0;
      tick(4);
   endtask

   task automatic t_debounce(bit lvl);
      logic [2:0] e;
      pin_raw[3:1] = {3{lvl}};
      for (int t = 1; t <= 12; t++) begin
         tick(1);
         e[0] = (t >= 7)  ? lvl : ~lvl;
         e[1] = (t >= 11) ? lvl : ~lvl;
         e[2] = (t >= 5)  ? lvl : ~lvl;
         chk("R3/R5 per-pin period", {29'd0, pin_out[3:1]}, {29'd0, e});
      end
   endtask

   task automatic t_glitch;
      bit seen = 1'b0;
      pin_raw[2] = 1'b1;
      tick(4);
      pin_raw[2] = 1'b0;
      for (int t = 0; t < 20; t++) begin
         tick(1);
         if (pin_out[2]) seen = 1'b1;
      end
      chk("R4 glitch rejected", {31'd0, seen}, 32'h0);
   endtask

   task automatic t_shared;
      wr(3'd2, 32'd2);
      pin_raw[5:4] = 2'b11;
      tick(3);
      chk("R9 shared old", {30'd0, pin_out[5:4]}, 32'h0);
      tick(1);
      chk("R9 shared new", {30'd0, pin_out[5:4]}, 32'h3);
      pin_raw[5:4] = 2'b00;
      tick(6);
   endtask

   task automatic t_zero_period;
      wr(3'd4, 32'd0);
      pin_raw[3] = 1'b1;
      tick(2);
      chk("R6 zero period old", {31'd0, pin_out[3]}, 32'h0);
      tick(1);
      chk("R6 zero period new", {31'd0, pin_out[3]}, 32'h1);
      pin_raw[3] = 1'b0;
      tick(4);
   endtask

   task automatic t_noncap;
      pin_raw[31] = 1'b1;
      tick(2);
      chk("R8 noncap old", {31'd0, pin_out[31]}, 32'h0);
      tick(1);
      chk("R8 noncap pass-through", {31'd0, pin_out[31]}, 32'h1);
      pin_raw[31] = 1'b0;
      tick(4);
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_regs();
      t_bypass();
      t_debounce(1'b1);
      t_debounce(1'b0);
      t_glitch();
      t_shared();
      t_zero_period();
      t_noncap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule